// File: doc/BRIEF.md
# Double-Buffered Converter Code Register

This block is the digital front end of a 10-bit digital-to-analog converter that a microprocessor loads over a narrow or a wide data bus. It holds two stages. A staging latch gathers the code, either with one wide write or with two byte writes. An output register holds the code that currently drives the converter. The output register changes only on a transfer event, so the processor can rebuild the staging latch over several writes without the converter output passing through half-written values.

The transfer trigger is chosen at run time by a two-bit mode input. In automatic mode the low-byte write that completes the word also copies it to the output. In write-strobe mode a separate write cycle with the transfer control raised does the copy. In external mode the transfer control alone, with no processor write, does the copy. A parameter chooses whether the code field sits at the top (left-justified) or the bottom (right-justified) of the bus. A one-cycle pulse marks each output update. All strobes are synchronous enables sampled on the system clock.

Top module: `dac_dbuf_top`

## Requirements
- R1: After reset, dacCode is 0, updPulse is 0 and the staging latch holds 0.
- R2: A write (wrStrobe high) with chipSel low leaves the staging latch unchanged.
- R3: A chip-selected write with byteSel=1 loads all 10 bits of the code field into the staging latch. The code field is dataBus[15:6] when LEFT_JUST=1 and dataBus[9:0] when LEFT_JUST=0.
- R4: A chip-selected write with byteSel=0 loads only staging latch bits [1:0] from code field bits [1:0]. Latch bits [9:2] keep their values.
- R5: In automatic mode (xferMode=0), a chip-selected write with byteSel=0 also copies the whole word, including the new bits [1:0], to the output. dacCode shows the word in the cycle after that clock edge. Wide writes and xferCtl cause no transfer in this mode.
- R6: In write-strobe mode (xferMode=1), a cycle with wrStrobe and xferCtl both high transfers the staging latch content held before that edge. chipSel is not needed for this transfer. Writes with xferCtl low cause no transfer.
- R7: In external mode (xferMode=2 or 3), xferCtl high transfers the staging latch content held before that edge, with or without a write. Writes never transfer in this mode.
- R8: dacCode keeps its value in every cycle that follows an edge without a transfer event.
- R9: updPulse is high for exactly the cycle after each transfer event and low otherwise. It fires even when the transferred value equals the old one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataBus | input | 16 | Processor data bus |
| chipSel | input | 1 | Active-high chip select for latch writes |
| wrStrobe | input | 1 | Write strobe, sampled as an enable |
| byteSel | input | 1 | 1: wide write of all 10 bits; 0: low-bits byte write |
| xferCtl | input | 1 | Transfer control / external transfer strobe |
| xferMode | input | 2 | 0 automatic, 1 write-strobe, 2 or 3 external |
| dacCode | output | 10 | Registered converter code |
| updPulse | output | 1 | One-cycle pulse on each output update |

## Verification
On every cycle the assertions check that the output holds without a transfer, that the update pulse follows exactly the transfer events, that a transfer from the staging latch copies the word held before the edge, and that each mode admits only its own trigger. The assertions cannot show that the right bus bits reach the right latch bits, that chip select gating works, or how a split word is built from its two bytes. The bench covers these through directed byte sequences and random traffic, with a left-justified and a right-justified instance compared against a model.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;

  typedef enum logic [1:0] {
    MODE_AUTO   = 2'd0,
    MODE_WRXFER = 2'd1,
    MODE_EXT    = 2'd2,
    MODE_EXT_B  = 2'd3
  } xfer_mode_e;

  typedef struct packed {
    logic loadAll;   // wide write into the whole staging latch
    logic loadLow;   // byte write into the low bits only
    logic xferNew;   // transfer the word as updated this cycle
    logic xferOld;   // transfer the word held before this cycle
  } dbuf_strobe_t;

endpackage

// File: rtl/dac_dbuf_ctrl.sv
module dac_dbuf_ctrl
  import dac_dbuf_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         chipSel,
  input  logic         wrStrobe,
  input  logic         byteSel,
  input  logic         xferCtl,
  input  logic [1:0]   xferMode,
  output dbuf_strobe_t strb
);

  xfer_mode_e modeSel;
  logic       wrEn;

  assign modeSel = xfer_mode_e'(xferMode);
  assign wrEn    = chipSel & wrStrobe;

  always_comb begin
    strb         = '0;
    strb.loadAll = wrEn & byteSel;
    strb.loadLow = wrEn & ~byteSel;
    unique case (modeSel)
      MODE_AUTO:   strb.xferNew = wrEn & ~byteSel;
      MODE_WRXFER: strb.xferOld = wrStrobe & xferCtl;
      default:     strb.xferOld = xferCtl;
    endcase
  end

  // R5: only a low-byte write in automatic mode may carry a fresh-word transfer
  assert_auto_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.xferNew |-> (xferMode == 2'd0 && chipSel && wrStrobe && !byteSel));

  // R6: write-strobe mode transfers need both strobe and control
  assert_wrxfer_needs_both_R6: assert property (@(posedge clk) disable iff (!rstN)
    (xferMode == 2'd1 && strb.xferOld) |-> (wrStrobe && xferCtl));

  // R7: external mode never transfers from a write alone
  assert_ext_no_write_xfer_R7: assert property (@(posedge clk) disable iff (!rstN)
    (xferMode[1] && (strb.xferNew || strb.xferOld)) |-> (strb.xferOld && xferCtl));

  assert_single_xfer_kind_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.xferNew, strb.xferOld}));

endmodule

// File: rtl/dac_dbuf_datapath.sv
module dac_dbuf_datapath
  import dac_dbuf_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int BUS_W     = 16,
  parameter int LSB_W     = 2,
  parameter bit LEFT_JUST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_W-1:0]  dataBus,
  input  dbuf_strobe_t      strb,
  output logic [CODE_W-1:0] dacCode,
  output logic              updPulse
);

  localparam int MSB_W = CODE_W - LSB_W;

  logic [CODE_W-1:0] codeField;
  logic [CODE_W-1:0] stageLatch;
  logic [CODE_W-1:0] stageNext;
  logic              unusedBus;

  generate
    if (LEFT_JUST) begin : g_left
      assign codeField = dataBus[BUS_W-1 -: CODE_W];
    end else begin : g_right
      assign codeField = dataBus[CODE_W-1:0];
    end
  endgenerate

  assign unusedBus = ^dataBus;

  always_comb begin
    stageNext = stageLatch;
    if (strb.loadAll)
      stageNext = codeField;
    else if (strb.loadLow)
      stageNext = {stageLatch[CODE_W-1 -: MSB_W], codeField[LSB_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageLatch <= '0;
      dacCode    <= '0;
      updPulse   <= 1'b0;
    end else begin
      stageLatch <= stageNext;
      updPulse   <= strb.xferNew | strb.xferOld;
      if (strb.xferNew)
        dacCode <= stageNext;
      else if (strb.xferOld)
        dacCode <= stageLatch;
    end
  end

  // R8: output holds when no transfer happened
  assert_dac_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.xferNew || strb.xferOld) |=> $stable(dacCode));

  // R9: pulse tracks transfer events one cycle later
  assert_pulse_on_xfer_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.xferNew || strb.xferOld) |=> updPulse);
  assert_pulse_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.xferNew || strb.xferOld) |=> !updPulse);

  // R7: an old-word transfer copies the latch held before the edge
  assert_old_copy_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.xferOld |=> (dacCode == $past(stageLatch)));

  // R4: a low byte write leaves the upper latch bits alone
  assert_low_keeps_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadLow && !strb.loadAll) |=>
      (stageLatch[CODE_W-1 -: MSB_W] == $past(stageLatch[CODE_W-1 -: MSB_W])));

endmodule

// File: rtl/dac_dbuf_top.sv
module dac_dbuf_top
  import dac_dbuf_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int BUS_W     = 16,
  parameter int LSB_W     = 2,
  parameter bit LEFT_JUST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_W-1:0]  dataBus,
  input  logic              chipSel,
  input  logic              wrStrobe,
  input  logic              byteSel,
  input  logic              xferCtl,
  input  logic [1:0]        xferMode,
  output logic [CODE_W-1:0] dacCode,
  output logic              updPulse
);

  dbuf_strobe_t strb;

  dac_dbuf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .chipSel  (chipSel),
    .wrStrobe (wrStrobe),
    .byteSel  (byteSel),
    .xferCtl  (xferCtl),
    .xferMode (xferMode),
    .strb     (strb)
  );

  dac_dbuf_datapath #(
    .CODE_W    (CODE_W),
    .BUS_W     (BUS_W),
    .LSB_W     (LSB_W),
    .LEFT_JUST (LEFT_JUST)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dataBus  (dataBus),
    .strb     (strb),
    .dacCode  (dacCode),
    .updPulse (updPulse)
  );

endmodule

// File: tb/dac_dbuf_top_tb.sv
module dac_dbuf_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] dataBus = '0;
  logic        chipSel = 1'b0, wrStrobe = 1'b0, byteSel = 1'b0, xferCtl = 1'b0;
  logic [1:0]  xferMode = 2'd0;
  logic [9:0]  dacL, dacR;
  logic        pulseL, pulseR;

  int checks = 0;
  int errors = 0;

  logic [9:0] mLatch [2];
  logic [9:0] mDac   [2];
  logic       mPulse [2];

  always #5 clk = ~clk;

  dac_dbuf_top #(.LEFT_JUST(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .dataBus(dataBus), .chipSel(chipSel),
    .wrStrobe(wrStrobe), .byteSel(byteSel), .xferCtl(xferCtl),
    .xferMode(xferMode), .dacCode(dacL), .updPulse(pulseL));

  dac_dbuf_top #(.LEFT_JUST(1'b0)) u_dutRj (
    .clk(clk), .rstN(rstN), .dataBus(dataBus), .chipSel(chipSel),
    .wrStrobe(wrStrobe), .byteSel(byteSel), .xferCtl(xferCtl),
    .xferMode(xferMode), .dacCode(dacR), .updPulse(pulseR));

  function automatic logic [9:0] fieldOf(input logic [15:0] bus, input int left);
    return left ? bus[15:6] : bus[9:0];
  endfunction

  task automatic modelReset();
    for (int k = 0; k < 2; k++) begin
      mLatch[k] = '0; mDac[k] = '0; mPulse[k] = 1'b0;
    end
  endtask

  task automatic modelEdge();
    for (int k = 0; k < 2; k++) begin
      logic [9:0] fld, nxt, src;
      logic       wr, xf;
      fld = fieldOf(dataBus, (k == 0) ? 1 : 0);
      wr  = chipSel & wrStrobe;
      nxt = mLatch[k];
      if (wr) nxt = byteSel ? fld : {mLatch[k][9:2], fld[1:0]};
      src = mLatch[k];
      xf  = 1'b0;
      if (xferMode == 2'd0) begin
        xf = wr & ~byteSel; src = nxt;
      end else if (xferMode == 2'd1) begin
        xf = wrStrobe & xferCtl;
      end else begin
        xf = xferCtl;
      end
      mLatch[k] = nxt;
      if (xf) mDac[k] = src;
      mPulse[k] = xf;
    end
  endtask

  task automatic check(input string tag);
    checks++;
    if (dacL !== mDac[0] || pulseL !== mPulse[0]) begin
      errors++;
      $display("FAIL %s left: dac=%h pulse=%b expected dac=%h pulse=%b",
               tag, dacL, pulseL, mDac[0], mPulse[0]);
    end
    checks++;
    if (dacR !== mDac[1] || pulseR !== mPulse[1]) begin
      errors++;
      $display("FAIL %s right: dac=%h pulse=%b expected dac=%h pulse=%b",
               tag, dacR, pulseR, mDac[1], mPulse[1]);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check(tag);
  endtask

  task automatic drive(input logic cs, input logic wr, input logic bs,
                       input logic xc, input logic [15:0] bus);
    chipSel = cs; wrStrobe = wr; byteSel = bs; xferCtl = xc; dataBus = bus;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check("R1 reset state");

    // R1: latch cleared, observed by an external transfer
    xferMode = 2'd2; drive(1'b0, 1'b0, 1'b0, 1'b1, 16'hFFFF);
    step("R1 latch zero after reset");
    idle(); step("R9 pulse drops");

    // R2: write without chip select ignored
    drive(1'b0, 1'b1, 1'b1, 1'b0, 16'hFFFF); step("R2 unselected write");
    drive(1'b0, 1'b0, 1'b0, 1'b1, 16'h0000); step("R2 latch unchanged");
    idle(); step("R8 hold after xfer");

    // R3: wide write, left and right justified fields differ
    drive(1'b1, 1'b1, 1'b1, 1'b0, 16'hA95A); step("R3 wide write");
    drive(1'b0, 1'b0, 1'b0, 1'b1, 16'h0000); step("R3 wide word transferred");

    // R4: low byte write changes only bits 1:0
    drive(1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF); step("R4 low byte write");
    drive(1'b0, 1'b0, 1'b0, 1'b1, 16'h0000); step("R4 low bits merged");
    idle(); step("R8 hold");

    // R7: writes never transfer in external mode, even with low byte
    drive(1'b1, 1'b1, 1'b0, 1'b0, 16'h0000); step("R7 write no transfer");
    // R7: transfer with simultaneous write uses old latch
    drive(1'b1, 1'b1, 1'b1, 1'b1, 16'h5555); step("R7 xfer takes old word");

    // R5: automatic mode, wide then low byte write
    xferMode = 2'd0;
    drive(1'b1, 1'b1, 1'b1, 1'b1, 16'hC3C3); step("R5 wide write no transfer");
    drive(1'b0, 1'b0, 1'b0, 1'b1, 16'h0000); step("R5 xferCtl ignored");
    drive(1'b1, 1'b1, 1'b0, 1'b0, 16'h0102); step("R5 second byte transfers");
    idle(); step("R9 single pulse");

    // R6: write-strobe mode
    xferMode = 2'd1;
    drive(1'b1, 1'b1, 1'b1, 1'b0, 16'h3CF0); step("R6 write no transfer");
    drive(1'b1, 1'b1, 1'b0, 1'b0, 16'h0003); step("R6 byte write no transfer");
    drive(1'b0, 1'b0, 1'b0, 1'b1, 16'h0000); step("R6 xferCtl without strobe");
    drive(1'b0, 1'b1, 1'b0, 1'b1, 16'h0000); step("R6 third strobe transfers");
    drive(1'b0, 1'b1, 1'b0, 1'b1, 16'h0000); step("R9 repeat transfer pulses");
    idle(); step("R8 hold");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      string tag;
      if ($urandom_range(0, 39) == 0) xferMode = 2'($urandom_range(0, 3));
      drive(($urandom_range(0, 3) != 0), $urandom_range(0, 1) == 1,
            $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
            16'($urandom()));
      case (xferMode)
        2'd0:    tag = "R5 random auto";
        2'd1:    tag = "R6 random strobe";
        default: tag = "R7 random external";
      endcase
      step(tag);
    end

    // reset mid-run
    idle();
    rstN = 1'b0;
    @(posedge clk);
    modelReset();
    @(negedge clk);
    rstN = 1'b1;
    check("R1 reset after traffic");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule